// File: doc/BRIEF.md
# Splittable 32/16-bit Auto-Reload Timer

The block holds one 32-bit counter that software can run either as a single wide timer or as two independent 16-bit timers. A split bit in the configuration word selects the mode at run time. In wide mode only the high-half fields steer the counter. In split mode the low and high halves each have their own run bit, master-enable bit, interrupt enables and flags. A global master-run bit and a debug-halt input gate all counting.

Count-enable pulses arrive from an external clock selector, one per half. The block exports the selector codes it stores so that the selector can choose the pulse source. Software reaches three 32-bit words through a simple register port: configuration, current count and reload value. Every counter that reaches all ones reloads on its next pulse and raises its overflow flag. Each half drives one level interrupt.

Top module: `split_timer_ctrl`

## Requirements
- R1: With split = 0, each high-side count pulse that the run gate lets through advances the whole 32-bit counter by one, with carry from bit 15 into bit 16. Low-side pulses have no effect.
- R2: The high (or wide) timer advances only when its run bit (config bit 29) is 1 and either its master-enable (bit 20) is 0 or master-run (bit 19) is 1.
- R3: The low half advances on a low-side pulse only when split (bit 5) is 1, its run bit (bit 13) is 1, and either its master-enable (bit 4) is 0 or master-run is 1.
- R4: A counter at all ones loads its reload value on the next pulse and sets its overflow flag. In split mode each half uses its own 16-bit half of the reload word. In wide mode the full 32-bit reload word is used and the high overflow flag (bit 31) is set.
- R5: The low overflow flag (bit 15) is set whenever the low 16 bits advance from all ones, in either mode.
- R6: Hardware never sets the extra flags (low bit 14, high bit 30).
- R7: irq_lo_o = (bit14 AND bit6) OR (bit15 AND bit7); irq_hi_o = (bit30 AND bit22) OR (bit31 AND bit23).
- R8: A configuration write sets each flag bit to the written value: 0 clears the flag, 1 forces it.
- R9: If hardware sets a flag in the same cycle that software writes 0 to it, the flag ends up set.
- R10: With debug mode (bit 21) = 1 and dbg_halt_i = 1, no counting occurs. With debug mode = 0, dbg_halt_i has no effect.
- R11: A write to the count word (address 1) loads the counter. It overrides any pulse in the same cycle, and that pulse sets no flag.
- R12: After reset, all three words read 0 and both interrupts are low. Address 0 is configuration, 1 is count, 2 is reload.
- R13: clk_sel_lo_o mirrors config bits 1:0 and clk_sel_hi_o mirrors bits 17:16. Unlisted configuration bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_lo_i | input | 1 | Count pulse for the low half |
| cnt_en_hi_i | input | 1 | Count pulse for the high half or wide timer |
| dbg_halt_i | input | 1 | Debug halt request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational on address |
| clk_sel_lo_o | output | 2 | Stored low clock-source select |
| clk_sel_hi_o | output | 2 | Stored high clock-source select |
| irq_lo_o | output | 1 | Low-half interrupt |
| irq_hi_o | output | 1 | High-half interrupt |

## Verification
Several properties are checked on every cycle. These are: counter loads, increments, reloads and holds; that no low tick appears in wide mode or during a debug halt; that an extra flag rises only on a configuration write; and that a hardware overflow set always leaves the flag high. Only the bench scenarios show the run-gating truth table, the carry between halves, the reload values, the read-back flag pattern, the interrupt equations and the count-write override.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CFG = 2'd0,
    ADDR_CNT = 2'd1,
    ADDR_RLD = 2'd2
  } reg_addr_e;

  localparam int CFG_W    = 32;
  localparam int B_LCLK   = 0;
  localparam int B_LMEN   = 4;
  localparam int B_SPLIT  = 5;
  localparam int B_LXIE   = 6;
  localparam int B_LOIE   = 7;
  localparam int B_LRUN   = 13;
  localparam int B_LXF    = 14;
  localparam int B_LOF    = 15;
  localparam int B_HCLK   = 16;
  localparam int B_MRUN   = 19;
  localparam int B_HMEN   = 20;
  localparam int B_DBG    = 21;
  localparam int B_HXIE   = 22;
  localparam int B_HOIE   = 23;
  localparam int B_HRUN   = 29;
  localparam int B_HXF    = 30;
  localparam int B_HOF    = 31;

  // plain storage bits (flags kept separately)
  localparam logic [CFG_W-1:0] CFG_RW_MASK =
      (32'h3 << B_LCLK) | (32'h1 << B_LMEN) | (32'h1 << B_SPLIT) |
      (32'h1 << B_LXIE) | (32'h1 << B_LOIE) | (32'h1 << B_LRUN)  |
      (32'h3 << B_HCLK) | (32'h1 << B_MRUN) | (32'h1 << B_HMEN)  |
      (32'h1 << B_DBG)  | (32'h1 << B_HXIE) | (32'h1 << B_HOIE)  |
      (32'h1 << B_HRUN);
endpackage

// File: rtl/stmr_run_gate.sv
module stmr_run_gate (
  input  logic split_i,
  input  logic mrun_i,
  input  logic lo_run_i,
  input  logic lo_men_i,
  input  logic hi_run_i,
  input  logic hi_men_i,
  input  logic dbg_mode_i,
  input  logic dbg_halt_i,
  input  logic cnt_en_lo_i,
  input  logic cnt_en_hi_i,
  output logic lo_tick_o,
  output logic hi_tick_o
);
  logic halt;
  logic lo_ok, hi_ok;

  assign halt  = dbg_mode_i & dbg_halt_i;
  assign hi_ok = hi_run_i & (~hi_men_i | mrun_i);
  assign lo_ok = split_i & lo_run_i & (~lo_men_i | mrun_i);

  assign lo_tick_o = cnt_en_lo_i & lo_ok & ~halt;
  assign hi_tick_o = cnt_en_hi_i & hi_ok & ~halt;
endmodule

// File: rtl/stmr_counter.sv
module stmr_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic         wrap_i,
  input  logic [W-1:0] rl_val_i,
  output logic [W-1:0] cnt_o,
  output logic         max_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_i) cnt_q <= wrap_i ? rl_val_i : cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
  assign max_o = &cnt_q;

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> cnt_q == $past(ld_val_i)); // R11
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && !wrap_i) |=> cnt_q == $past(cnt_q) + W'(1)); // R1
  AST_CNT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i && wrap_i) |=> cnt_q == $past(rl_val_i)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/stmr_flags.sv
module stmr_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] hw_set_i,
  input  logic         sw_we_i,
  input  logic [N-1:0] sw_val_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= 1'b0;
      else if (hw_set_i[i]) q <= 1'b1;     // hardware set beats software clear
      else if (sw_we_i)     q <= sw_val_i[i];
    end
    assign flag_o[i] = q;

    AST_FLAG_HW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_set_i[i] |=> flag_o[i]); // R9
  end
endmodule

// File: rtl/split_timer_ctrl.sv
module split_timer_ctrl
  import split_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_lo_i,
  input  logic             cnt_en_hi_i,
  input  logic             dbg_halt_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  output logic [1:0]       clk_sel_lo_o,
  output logic [1:0]       clk_sel_hi_o,
  output logic             irq_lo_o,
  output logic             irq_hi_o
);
  localparam int HALF_W = CNT_W / 2;
  localparam int NFLAG  = 4;
  localparam int F_LX = 0, F_LO = 1, F_HX = 2, F_HO = 3;

  logic [CFG_W-1:0]  cfg_q;
  logic [CNT_W-1:0]  rld_q;
  logic              cfg_we, cnt_we, rld_we;
  logic              split;
  logic              lo_tick, hi_tick;
  logic [HALF_W-1:0] lo_cnt, hi_cnt;
  logic              lo_max, hi_max;
  logic              lo_inc, hi_inc, lo_wrap, hi_wrap;
  logic [NFLAG-1:0]  hw_set, sw_val, flags;
  logic [CFG_W-1:0]  cfg_rd;

  assign cfg_we = reg_we_i && (reg_addr_i == ADDR_CFG);
  assign cnt_we = reg_we_i && (reg_addr_i == ADDR_CNT);
  assign rld_we = reg_we_i && (reg_addr_i == ADDR_RLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      rld_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= reg_wdata_i & CFG_RW_MASK;
      if (rld_we) rld_q <= reg_wdata_i;
    end
  end

  assign split = cfg_q[B_SPLIT];

  stmr_run_gate u_gate (
    .split_i     (split),
    .mrun_i      (cfg_q[B_MRUN]),
    .lo_run_i    (cfg_q[B_LRUN]),
    .lo_men_i    (cfg_q[B_LMEN]),
    .hi_run_i    (cfg_q[B_HRUN]),
    .hi_men_i    (cfg_q[B_HMEN]),
    .dbg_mode_i  (cfg_q[B_DBG]),
    .dbg_halt_i  (dbg_halt_i),
    .cnt_en_lo_i (cnt_en_lo_i),
    .cnt_en_hi_i (cnt_en_hi_i),
    .lo_tick_o   (lo_tick),
    .hi_tick_o   (hi_tick)
  );

  // wide mode: low half steps on the high tick, high half on carry
  assign lo_inc  = (split ? lo_tick : hi_tick) & ~cnt_we;
  assign hi_inc  = (split ? hi_tick : hi_tick & lo_max) & ~cnt_we;
  assign lo_wrap = lo_max & (split | hi_max);
  assign hi_wrap = hi_max & (split | lo_max);

  stmr_counter #(.W(HALF_W)) u_cnt_lo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cnt_we),
    .ld_val_i (reg_wdata_i[HALF_W-1:0]),
    .inc_i    (lo_inc),
    .wrap_i   (lo_wrap),
    .rl_val_i (rld_q[HALF_W-1:0]),
    .cnt_o    (lo_cnt),
    .max_o    (lo_max)
  );

  stmr_counter #(.W(HALF_W)) u_cnt_hi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (cnt_we),
    .ld_val_i (reg_wdata_i[CNT_W-1:HALF_W]),
    .inc_i    (hi_inc),
    .wrap_i   (hi_wrap),
    .rl_val_i (rld_q[CNT_W-1:HALF_W]),
    .cnt_o    (hi_cnt),
    .max_o    (hi_max)
  );

  always_comb begin
    hw_set       = '0;
    hw_set[F_LO] = lo_inc & lo_max;
    hw_set[F_HO] = hi_inc & hi_max;
    sw_val       = '0;
    sw_val[F_LX] = reg_wdata_i[B_LXF];
    sw_val[F_LO] = reg_wdata_i[B_LOF];
    sw_val[F_HX] = reg_wdata_i[B_HXF];
    sw_val[F_HO] = reg_wdata_i[B_HOF];
  end

  stmr_flags #(.N(NFLAG)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_set_i (hw_set),
    .sw_we_i  (cfg_we),
    .sw_val_i (sw_val),
    .flag_o   (flags)
  );

  always_comb begin
    cfg_rd        = cfg_q;
    cfg_rd[B_LXF] = flags[F_LX];
    cfg_rd[B_LOF] = flags[F_LO];
    cfg_rd[B_HXF] = flags[F_HX];
    cfg_rd[B_HOF] = flags[F_HO];
    unique case (reg_addr_i)
      ADDR_CFG: reg_rdata_o = cfg_rd;
      ADDR_CNT: reg_rdata_o = {hi_cnt, lo_cnt};
      ADDR_RLD: reg_rdata_o = rld_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign clk_sel_lo_o = cfg_q[B_LCLK +: 2];
  assign clk_sel_hi_o = cfg_q[B_HCLK +: 2];
  assign irq_lo_o = (flags[F_LX] & cfg_q[B_LXIE]) | (flags[F_LO] & cfg_q[B_LOIE]);
  assign irq_hi_o = (flags[F_HX] & cfg_q[B_HXIE]) | (flags[F_HO] & cfg_q[B_HOIE]);

  AST_LO_IDLE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !split |-> !lo_tick); // R3
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[B_DBG] && dbg_halt_i) |-> !(lo_tick || hi_tick)); // R10
  AST_LXF_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_LX]) |-> $past(cfg_we)); // R6
  AST_HXF_SW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[F_HX]) |-> $past(cfg_we)); // R6
endmodule

// File: tb/split_timer_ctrl_tb.sv
module split_timer_ctrl_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] C_SPLIT = 32'h1 << 5,  C_LRUN = 32'h1 << 13, C_LMEN = 32'h1 << 4;
  localparam logic [31:0] C_HRUN  = 32'h1 << 29, C_HMEN = 32'h1 << 20, C_MRUN = 32'h1 << 19;
  localparam logic [31:0] C_DBG   = 32'h1 << 21;
  localparam logic [31:0] C_LXIE  = 32'h1 << 6,  C_LOIE = 32'h1 << 7;
  localparam logic [31:0] C_HXIE  = 32'h1 << 22, C_HOIE = 32'h1 << 23;
  localparam logic [31:0] F_LX = 32'h1 << 14, F_LO = 32'h1 << 15;
  localparam logic [31:0] F_HX = 32'h1 << 30, F_HO = 32'h1 << 31;

  // {split, lo_run, lo_men, hi_run, hi_men, mrun, expected count after one pulse on each side}
  localparam int NV = 9;
  localparam logic [37:0] VEC [NV] = '{
    {6'b000100, 32'h0000_0001},
    {6'b000110, 32'h0000_0000},
    {6'b000111, 32'h0000_0001},
    {6'b011000, 32'h0000_0000},
    {6'b110100, 32'h0001_0001},
    {6'b111100, 32'h0001_0000},
    {6'b111001, 32'h0000_0001},
    {6'b100100, 32'h0001_0000},
    {6'b000101, 32'h0000_0001}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cnt_en_lo_i = 1'b0, cnt_en_hi_i = 1'b0, dbg_halt_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [1:0]  clk_sel_lo_o, clk_sel_hi_o;
  logic        irq_lo_o, irq_hi_o;

  int checks = 0, errors = 0;

  split_timer_ctrl u_dut (
    .clk_i, .rst_ni, .cnt_en_lo_i, .cnt_en_hi_i, .dbg_halt_i,
    .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .clk_sel_lo_o, .clk_sel_hi_o, .irq_lo_o, .irq_hi_o
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic pulse(input logic lo, input logic hi);
    @(negedge clk_i);
    cnt_en_lo_i = lo; cnt_en_hi_i = hi;
    @(negedge clk_i);
    cnt_en_lo_i = 1'b0; cnt_en_hi_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] cfg;
    #(CLK_P * 2 + 2);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 reset state
    rd(2'd0, v); chk("R12 cfg reset", v, 32'h0);
    rd(2'd1, v); chk("R12 count reset", v, 32'h0);
    rd(2'd2, v); chk("R12 reload reset", v, 32'h0);
    chk("R12 irq reset", {30'h0, irq_hi_o, irq_lo_o}, 32'h0);

    // R1 R2 R3 run gating table
    for (int i = 0; i < NV; i++) begin
      cfg = (VEC[i][37] ? C_SPLIT : 0) | (VEC[i][36] ? C_LRUN : 0) | (VEC[i][35] ? C_LMEN : 0) |
            (VEC[i][34] ? C_HRUN : 0) | (VEC[i][33] ? C_HMEN : 0) | (VEC[i][32] ? C_MRUN : 0);
      wr(2'd0, cfg);
      wr(2'd1, 32'h0);
      pulse(1'b1, 1'b1);
      rd(2'd1, v);
      chk($sformatf("R2 R3 gating row %0d", i), v, VEC[i][31:0]);
    end

    // R1 carry across halves in wide mode
    wr(2'd0, C_HRUN);
    wr(2'd1, 32'h0000_FFFE);
    pulse(1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R1 carry", v, 32'h0001_0000);

    // R4 split reload per half
    wr(2'd2, 32'h0005_0003);
    wr(2'd0, C_SPLIT | C_LRUN | C_HRUN | C_LOIE | C_HOIE);
    wr(2'd1, 32'hFFFF_FFFF);
    pulse(1'b1, 1'b1);
    rd(2'd1, v); chk("R4 split reload", v, 32'h0005_0003);
    rd(2'd0, v); chk("R4 R6 split flags", v, C_SPLIT | C_LRUN | C_HRUN | C_LOIE | C_HOIE | F_LO | F_HO);
    chk("R7 irq overflow enabled", {30'h0, irq_hi_o, irq_lo_o}, 32'h3);
    pulse(1'b1, 1'b1);
    rd(2'd1, v); chk("R4 post-reload step", v, 32'h0006_0004);

    // R4 R5 wide reload
    wr(2'd0, C_HRUN);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd2, 32'h1234_5678);
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R4 wide reload", v, 32'h1234_5678);
    rd(2'd0, v); chk("R4 R5 wide flags", v, C_HRUN | F_LO | F_HO);
    chk("R7 irq enables off", {30'h0, irq_hi_o, irq_lo_o}, 32'h0);

    // R5 low wrap in wide mode sets only low overflow
    wr(2'd0, C_HRUN | C_LOIE | C_HOIE);
    wr(2'd1, 32'h0000_FFFF);
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R5 wide low wrap count", v, 32'h0001_0000);
    rd(2'd0, v); chk("R5 wide low wrap flags", v, C_HRUN | C_LOIE | C_HOIE | F_LO);
    chk("R7 irq low only", {30'h0, irq_hi_o, irq_lo_o}, 32'h1);

    // R8 R7 software force and clear of extra flags
    wr(2'd0, C_SPLIT | F_LX);
    rd(2'd0, v); chk("R8 force low extra", v, C_SPLIT | F_LX);
    chk("R7 extra without enable", {31'h0, irq_lo_o}, 32'h0);
    wr(2'd0, C_SPLIT | C_LXIE | F_LX | C_HXIE | F_HX);
    chk("R7 extra with enable", {30'h0, irq_hi_o, irq_lo_o}, 32'h3);
    wr(2'd0, C_SPLIT | C_LXIE | C_HXIE);
    rd(2'd0, v); chk("R8 clear extra", v, C_SPLIT | C_LXIE | C_HXIE);
    chk("R8 irq after clear", {30'h0, irq_hi_o, irq_lo_o}, 32'h0);

    // R9 hardware set beats simultaneous software clear
    wr(2'd0, C_HRUN);
    wr(2'd1, 32'hFFFF_FFFF);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = C_HRUN; cnt_en_hi_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; cnt_en_hi_i = 1'b0;
    rd(2'd0, v); chk("R9 set wins over clear", v, C_HRUN | F_LO | F_HO);

    // R10 debug halt
    wr(2'd0, C_HRUN | C_DBG);
    wr(2'd1, 32'h10);
    dbg_halt_i = 1'b1;
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R10 halted", v, 32'h10);
    wr(2'd0, C_HRUN);
    pulse(1'b0, 1'b1);
    rd(2'd1, v); chk("R10 halt ignored in run mode", v, 32'h11);
    dbg_halt_i = 1'b0;

    // R11 count write overrides pulse, no flag
    wr(2'd1, 32'hFFFF_FFFF);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 32'h0000_0500; cnt_en_hi_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0; cnt_en_hi_i = 1'b0;
    rd(2'd1, v); chk("R11 write wins", v, 32'h0000_0500);
    rd(2'd0, v); chk("R11 no flag on override", v, C_HRUN);

    // R13 selector outputs and unlisted bits
    wr(2'd0, 32'h0003_0002 | 32'h0F00_0F00);
    chk("R13 clk sel", {28'h0, clk_sel_hi_o, clk_sel_lo_o}, 32'hE);
    rd(2'd0, v); chk("R13 unlisted bits", v, 32'h0003_0002);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule